// File: doc/BRIEF.md
# Paged Display Memory Host Port

This block is the host-facing side of a bit-mapped display memory. The memory holds eight full pages plus one indicator row, and each page is eight pixel rows tall and 256 columns wide. A host reaches it over a byte-wide command port. It first loads a page pointer and a column pointer with two address commands. It then moves bytes with data read and data write commands. Each byte is a vertical strip of eight rows at the addressed page and column. Bit 0 is the top row of the strip and bit 7 is the bottom row.

After every data access the column pointer steps forward by one, so a host can stream a run of bytes across a page. The pointer stops at the last column and never carries into the page pointer. Moving to another page always takes a new page command. The ninth page (page 8) is a single-bit indicator row. Page values above 8 select nothing.

Top module: `paged_dram_port`

## Requirements
- R1: After reset the page pointer and column pointer are 0, `rdata` is 0 and `rd_valid` is 0.
- R2: A strobe with `op`=0 loads the page pointer from `wdata[3:0]` and leaves the column pointer unchanged.
- R3: A strobe with `op`=1 loads the column pointer from `wdata[7:0]` and leaves the page pointer unchanged.
- R4: A strobe with `op`=2 stores `wdata` at the current page and column, with bit k in row k of that page. A strobe with `op`=3 returns the stored byte on `rdata`, with `rd_valid` high for exactly the one cycle after the strobe. Each page keeps its own bytes.
- R5: Each read or write strobe advances the column pointer by one. Address set strobes do not advance it.
- R6: At column 255 the column pointer stays at 255, so further accesses keep hitting column 255.
- R7: Reaching the end of a page never changes the page pointer, and the next page is left untouched.
- R8: On page 8 only bit 0 is stored. Bits 7..1 are ignored on writes and read back as 0.
- R9: On pages 9 to 15 writes are dropped and reads return 0, but the column pointer still advances.
- R10: When `req` is low, `op` and `wdata` have no effect on the memory or on either pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Command strobe, one command per cycle |
| op | input | 2 | 0 set page, 1 set column, 2 write data, 3 read data |
| wdata | input | 8 | Address value or data byte |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | High on the cycle after a read strobe |

## Verification
The bench drives the column pointer into 255 and keeps writing. A design that wraps would overwrite column 0, and a design that carries would spill into the next page; both show up on readback. On the indicator page it writes all-ones and all-but-bit-0 bytes, so upper bits that leak through, or a lost bit 0, are caught. It also uses an invalid page to prove that writes there vanish while the column still steps. Finally it checks that address commands and idle cycles carrying write codes leave both pointers and the stored data alone.

// File: rtl/paged_dram_port.sv
module paged_dram_port #(
  parameter int PAGES = 8,
  parameter int COL_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req,
  input  logic [1:0] op,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rd_valid
);
  localparam int PG_W = $clog2(PAGES);
  localparam int COLS = 1 << COL_W;
  localparam logic [COL_W-1:0] COL_END = '1;
  localparam logic [3:0] IND_PAGE = 4'(PAGES);

  logic [3:0]       page;
  logic [COL_W-1:0] col;
  logic [7:0]       mem [PAGES*COLS];
  logic             ind [COLS];

  wire set_pg  = req && op == 2'd0;
  wire set_col = req && op == 2'd1;
  wire is_wr   = req && op == 2'd2;
  wire is_rd   = req && op == 2'd3;
  wire data_op = is_wr || is_rd;
  wire main_pg = page < IND_PAGE;
  wire ind_pg  = page == IND_PAGE;
  wire [PG_W+COL_W-1:0] addr = {page[PG_W-1:0], col};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page     <= '0;
      col      <= '0;
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= is_rd;
      if (set_pg)  page <= wdata[3:0];
      if (set_col) col  <= wdata[COL_W-1:0];
      if (data_op && col != COL_END) col <= col + 1'b1;
      if (is_rd)
        rdata <= main_pg ? mem[addr] : ind_pg ? {7'b0, ind[col]} : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (is_wr && main_pg) mem[addr] <= wdata;
    if (is_wr && ind_pg)  ind[col]  <= wdata[0];
  end

  a_r2_page_set_keeps_col: assert property (@(posedge clk) disable iff (!rst_n)
    set_pg |=> col == $past(col));
  a_r3_col_set_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    set_col |=> page == $past(page));
  a_r4_rd_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    is_rd |=> rd_valid);
  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (data_op && col != COL_END) |=> col == COL_W'($past(col) + 1'b1));
  a_r6_col_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (data_op && col == COL_END) |=> col == COL_END);
  a_r7_page_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
    data_op |=> page == $past(page));
  a_r8_ind_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && ind_pg) |=> rdata[7:1] == 7'd0);
  a_r9_bad_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && page > IND_PAGE) |=> rdata == 8'h00);
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> (col == $past(col) && page == $past(page)));
endmodule

// File: tb/paged_dram_port_tb.sv
module paged_dram_port_tb;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rd_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_dram_port u_dut (.clk(clk), .rst_n(rst_n), .req(req), .op(op),
                         .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid));

  task automatic chk(string req_tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] o, logic [7:0] d);
    @(negedge clk); req = 1'b1; op = o; wdata = d;
    @(negedge clk); req = 1'b0; op = 2'd0; wdata = 8'h00;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); req = 1'b1; op = 2'd3;
    @(negedge clk); req = 1'b0; op = 2'd0;
    v = rdata;
  endtask

  task automatic goto(logic [3:0] p, logic [7:0] c);
    cmd(2'd0, {4'h0, p}); cmd(2'd1, c);
  endtask

  task automatic expect_at(string t, logic [3:0] p, logic [7:0] c, logic [7:0] e);
    logic [7:0] v;
    goto(p, c); rd(v); chk(t, v, e);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 rd_valid", {7'b0, rd_valid}, 8'h00);
    cmd(2'd2, 8'hC3);
    cmd(2'd0, 8'h00); cmd(2'd1, 8'h00); rd(v);
    chk("R1 pointers start at page 0 col 0", v, 8'hC3);
  endtask

  task automatic t_roundtrip();
    logic [7:0] v;
    goto(4'd1, 8'd10); cmd(2'd2, 8'hA1);
    goto(4'd2, 8'd10); cmd(2'd2, 8'hB2);
    expect_at("R4 page1 byte", 4'd1, 8'd10, 8'hA1);
    expect_at("R4 page2 byte", 4'd2, 8'd10, 8'hB2);
    goto(4'd1, 8'd10);
    @(negedge clk); req = 1'b1; op = 2'd3;
    @(negedge clk); req = 1'b0;
    chk("R4 rd_valid high", {7'b0, rd_valid}, 8'h01);
    @(negedge clk);
    chk("R4 rd_valid one cycle", {7'b0, rd_valid}, 8'h00);
    v = rdata; chk("R4 rdata held", v, 8'hA1);
  endtask

  task automatic t_increment();
    logic [7:0] v;
    goto(4'd3, 8'd40);
    cmd(2'd2, 8'h11); cmd(2'd2, 8'h22); cmd(2'd2, 8'h33);
    cmd(2'd1, 8'd40);
    rd(v); chk("R5 first", v, 8'h11);
    rd(v); chk("R5 second after read step", v, 8'h22);
    rd(v); chk("R5 third", v, 8'h33);
    goto(4'd3, 8'd50); cmd(2'd2, 8'h5A); cmd(2'd2, 8'h6B);
    cmd(2'd1, 8'd50); cmd(2'd0, 8'd3); cmd(2'd0, 8'd3);
    rd(v); chk("R2 page set keeps column", v, 8'h5A);
    cmd(2'd0, 8'd3); cmd(2'd1, 8'd51); cmd(2'd0, 8'd3);
    rd(v); chk("R3 column set no step", v, 8'h6B);
  endtask

  task automatic t_saturate();
    logic [7:0] v;
    goto(4'd5, 8'h00); cmd(2'd2, 8'h5A);
    goto(4'd4, 8'h00); cmd(2'd2, 8'h77);
    goto(4'd4, 8'hFE);
    cmd(2'd2, 8'h01); cmd(2'd2, 8'h02); cmd(2'd2, 8'h03); cmd(2'd2, 8'h04);
    expect_at("R6 col FE", 4'd4, 8'hFE, 8'h01);
    rd(v); chk("R6 col FF last write", v, 8'h04);
    rd(v); chk("R6 stays at FF", v, 8'h04);
    expect_at("R6 no wrap to col 0", 4'd4, 8'h00, 8'h77);
    expect_at("R7 next page untouched", 4'd5, 8'h00, 8'h5A);
    goto(4'd4, 8'hFF); cmd(2'd2, 8'h99);
    cmd(2'd1, 8'h00); rd(v);
    chk("R7 page unchanged after end", v, 8'h77);
  endtask

  task automatic t_indicator();
    logic [7:0] v;
    goto(4'd8, 8'd4); cmd(2'd2, 8'hFF); cmd(2'd2, 8'hFE);
    expect_at("R8 bit0 only", 4'd8, 8'd4, 8'h01);
    rd(v); chk("R8 upper bits ignored", v, 8'h00);
  endtask

  task automatic t_bad_page();
    logic [7:0] v;
    goto(4'd0, 8'd5); cmd(2'd2, 8'h3C);
    goto(4'd9, 8'd5); cmd(2'd2, 8'hEE);
    cmd(2'd0, 8'd0); cmd(2'd2, 8'h7E);
    expect_at("R9 write dropped", 4'd0, 8'd5, 8'h3C);
    rd(v); chk("R9 column still stepped", v, 8'h7E);
    expect_at("R9 read returns 0", 4'd15, 8'd5, 8'h00);
  endtask

  task automatic t_idle();
    logic [7:0] v;
    goto(4'd6, 8'd9); cmd(2'd2, 8'h42); cmd(2'd1, 8'd9);
    @(negedge clk); op = 2'd2; wdata = 8'hBD;
    @(negedge clk); op = 2'd0; wdata = 8'h07;
    @(negedge clk); op = 2'd1; wdata = 8'h80;
    @(negedge clk); op = 2'd0; wdata = 8'h00;
    rd(v); chk("R10 idle cycles ignored", v, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_roundtrip();
    t_increment();
    t_saturate();
    t_indicator();
    t_bad_page();
    t_idle();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule